// File: doc/BRIEF.md
# Base Address Window Set with Request Decode

This block keeps the six base address slots of an endpoint's type 0 configuration header together with the two space-enable bits of its command register. It decodes each incoming request address into a hit flag, the number of the window that claimed it and the offset inside that window. Every window is fixed at elaboration by three parameters: its kind (unused, I/O, 32-bit memory or 64-bit memory), a prefetchable flag and the base-two logarithm of its size. A 64-bit memory window takes its own slot and the slot after it.

Configuration software reaches the slots and the command register through whole 32-bit dword reads and writes, addressed by dword index. It sizes a window by writing all ones and reading the result back, then programs a base and sets the enables. The request side is a single-cycle strobe carrying the address and a flag for I/O space. Its decode result appears on registered outputs in the next cycle. Routing the request onward is left to the surrounding logic.

The block has no state machine. It consists of a register file, a compare per window, a lowest-index pick and one output register stage.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every slot's address bits and both enables are zero, so a slot reads back only its fixed type bits and no request hits.
- R2: A window of size 2^n (n at least 4) stores only the address bits at and above bit n. Writing all ones to its first slot reads back those bits combined with the type bits.
- R3: Type bits read from a window's first slot are 0x1 for I/O, 0x0 for 32-bit memory and 0x4 for 64-bit memory. Bit 3 (0x8) is added when a memory window is prefetchable.
- R4: A 64-bit window's second slot holds address bits 63:32. It is fully writable when n < 32. When n >= 32 its writable bits start at bit n-32 and the first slot has no writable address bits.
- R5: Reads of dword indices other than 1 (command) and 4 to 9 (slots), and reads of slots configured unused, return zero, and writes to them change nothing. A hit never reports a slot that does not start a window.
- R6: A memory request hits a window when its address lies in [base, base + 2^n). The base is the slot value with its low four bits cleared, joined with the second slot above it for 64-bit windows and with zero above it otherwise. The reported offset is the address minus the base.
- R7: A window only claims requests of its own space: I/O windows only requests flagged I/O, memory windows only requests not so flagged.
- R8: Memory windows decode only while command bit 1 is set, and I/O windows only while command bit 0 is set. A write to a slot or to the command register applies to a request presented in the very next cycle.
- R9: When several windows match, the lowest-numbered one is reported.
- R10: The decode result is registered: it appears the cycle after the request strobe. A cycle without a strobe, or a miss, gives hit 0 with index and offset 0.
- R11: A configuration read returns its data on cfg_rdata in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 for write, 0 for read |
| cfg_dw | input | DW_W | Dword index in configuration space (1 command, 4 to 9 slots) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after a read |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | Request targets I/O space |
| req_addr | input | 64 | Request address |
| hit | output | 1 | A window claimed the request |
| hit_idx | output | IDX_W | Slot number of the claiming window |
| hit_off | output | 64 | Offset within the claiming window |

## Verification
The decode is driven with addresses on the first and last byte of each window and one byte past it. The same addresses are also sent with the opposite space flag and with nonzero upper address bits, which separates range errors from space and width errors. The 64-bit windows are tried with one whose size sits below 2^32 and one above it, so a fault in the upper-dword mask shows up in just one of them. Overlapping windows, enables cleared in the cycle right before a request, and the sizing reads of every slot check priority, live gating and the per-slot masks.

// File: rtl/bardec_pkg.sv
package bardec_pkg;

    localparam int NSLOT = 6;
    localparam int IDX_W = $clog2(NSLOT);

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_IO    = 2'd1,
        KIND_MEM32 = 2'd2,
        KIND_MEM64 = 2'd3
    } bar_kind_e;

    typedef enum logic [1:0] {
        ROLE_IDLE  = 2'd0,
        ROLE_BASE  = 2'd1,
        ROLE_UPPER = 2'd2
    } slot_role_e;

    function automatic int log_at(input logic [6*NSLOT-1:0] logs, input int s);
        return int'(logs[6*s +: 6]);
    endfunction

    // Walks the slots in order; a 64-bit window consumes the following slot.
    function automatic slot_role_e slot_role(input logic [2*NSLOT-1:0] kinds, input int s);
        slot_role_e r;
        logic       pend;
        r    = ROLE_IDLE;
        pend = 1'b0;
        for (int j = 0; j < NSLOT; j++) begin
            if (j <= s) begin
                if (pend) begin
                    r    = ROLE_UPPER;
                    pend = 1'b0;
                end else if (kinds[2*j +: 2] == KIND_NONE ||
                             (kinds[2*j +: 2] == KIND_MEM64 && j == NSLOT - 1)) begin
                    r = ROLE_IDLE;
                end else begin
                    r    = ROLE_BASE;
                    pend = (kinds[2*j +: 2] == KIND_MEM64);
                end
            end
        end
        return r;
    endfunction

    function automatic logic [NSLOT-1:0] base_set(input logic [2*NSLOT-1:0] kinds);
        logic [NSLOT-1:0] v;
        for (int j = 0; j < NSLOT; j++) v[j] = (slot_role(kinds, j) == ROLE_BASE);
        return v;
    endfunction

    function automatic logic [NSLOT-1:0] io_set(input logic [2*NSLOT-1:0] kinds);
        logic [NSLOT-1:0] v;
        for (int j = 0; j < NSLOT; j++)
            v[j] = (slot_role(kinds, j) == ROLE_BASE) && (kinds[2*j +: 2] == KIND_IO);
        return v;
    endfunction

    function automatic logic [31:0] lo_mask(input int lg);
        return (lg >= 32) ? 32'h0 : (32'hFFFF_FFFF << lg);
    endfunction

    function automatic logic [31:0] hi_mask(input int lg);
        return (lg >= 32) ? (32'hFFFF_FFFF << (lg - 32)) : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] type_bits(input logic [1:0] k, input logic pf);
        logic [31:0] t;
        unique case (k)
            KIND_IO:    t = 32'h1;
            KIND_MEM32: t = {28'h0, pf, 3'b000};
            KIND_MEM64: t = {28'h0, pf, 3'b100};
            default:    t = 32'h0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/bardec_regs.sv
module bardec_regs
    import bardec_pkg::*;
#(
    parameter logic [2*NSLOT-1:0] SLOT_KIND = 12'h336,
    parameter logic [NSLOT-1:0]   SLOT_PREF = 6'b000100,
    parameter logic [6*NSLOT-1:0] SLOT_LOG2 = {6'd0, 6'd33, 6'd0, 6'd20, 6'd5, 6'd12},
    parameter int                 DW_W      = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic                   cfg_we,
    input  logic [DW_W-1:0]        cfg_dw,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    output logic [NSLOT-1:0][31:0] slot_val,
    output logic                   cmd_io,
    output logic                   cmd_mem
);

    localparam int              FIRST_DW = 4;
    localparam logic [DW_W-1:0] CMD_DW   = DW_W'(1);

    logic [NSLOT-1:0][31:0] slot_rd;
    logic [31:0]            rd_next;
    logic                   wr_any;

    assign wr_any = cfg_en && cfg_we;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam slot_role_e      ROLE  = slot_role(SLOT_KIND, s);
        localparam int              PREV  = (s > 0) ? s - 1 : 0;
        localparam logic [31:0]     WMASK = (ROLE == ROLE_BASE)  ? lo_mask(log_at(SLOT_LOG2, s)) :
                                            (ROLE == ROLE_UPPER) ? hi_mask(log_at(SLOT_LOG2, PREV)) :
                                            32'h0;
        localparam logic [31:0]     FIXED = (ROLE == ROLE_BASE) ?
                                            type_bits(SLOT_KIND[2*s +: 2], SLOT_PREF[s]) : 32'h0;
        localparam logic [DW_W-1:0] MY_DW = DW_W'(FIRST_DW + s);

        logic [31:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= 32'h0;
            end else if (wr_any && cfg_dw == MY_DW) begin
                val_q <= cfg_wdata & WMASK;
            end
        end

        assign slot_val[s] = val_q;
        assign slot_rd[s]  = val_q | FIXED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_io  <= 1'b0;
            cmd_mem <= 1'b0;
        end else if (wr_any && cfg_dw == CMD_DW) begin
            cmd_io  <= cfg_wdata[0];
            cmd_mem <= cfg_wdata[1];
        end
    end

    always_comb begin
        rd_next = 32'h0;
        if (cfg_dw == CMD_DW) rd_next = {30'h0, cmd_mem, cmd_io};
        for (int s = 0; s < NSLOT; s++) begin
            if (cfg_dw == DW_W'(FIRST_DW + s)) rd_next = slot_rd[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= 32'h0;
        end else if (cfg_en && !cfg_we) begin
            cfg_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/bardec_match.sv
module bardec_match
    import bardec_pkg::*;
#(
    parameter logic [2*NSLOT-1:0] SLOT_KIND = 12'h336,
    parameter logic [6*NSLOT-1:0] SLOT_LOG2 = {6'd0, 6'd33, 6'd0, 6'd20, 6'd5, 6'd12}
) (
    input  logic [NSLOT-1:0][31:0] slot_val,
    input  logic                   cmd_io,
    input  logic                   cmd_mem,
    input  logic                   req_is_io,
    input  logic [63:0]            req_addr,
    output logic [NSLOT-1:0]       match,
    output logic [NSLOT-1:0][63:0] offset
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        localparam slot_role_e ROLE = slot_role(SLOT_KIND, s);

        if (ROLE == ROLE_BASE) begin : g_live
            localparam logic [1:0]  KIND   = SLOT_KIND[2*s +: 2];
            localparam int          NXT    = (s < NSLOT - 1) ? s + 1 : s;
            localparam int          LG     = log_at(SLOT_LOG2, s);
            localparam logic        WIDE   = (KIND == KIND_MEM64);
            localparam logic [63:0] MASK64 = {WIDE ? hi_mask(LG) : 32'hFFFF_FFFF, lo_mask(LG)};

            logic [63:0] base;
            logic        space_ok;

            assign base     = {WIDE ? slot_val[NXT] : 32'h0, slot_val[s] & 32'hFFFF_FFF0};
            assign space_ok = (KIND == KIND_IO) ? (req_is_io && cmd_io) : (!req_is_io && cmd_mem);
            assign match[s]  = space_ok && (((req_addr ^ base) & MASK64) == 64'h0);
            assign offset[s] = req_addr & ~MASK64;
        end else begin : g_idle
            assign match[s]  = 1'b0;
            assign offset[s] = 64'h0;
        end
    end

endmodule

// File: rtl/bardec_pick.sv
module bardec_pick
    import bardec_pkg::*;
(
    input  logic [NSLOT-1:0]       match,
    input  logic [NSLOT-1:0][63:0] offset,
    output logic                   any,
    output logic [IDX_W-1:0]       idx,
    output logic [63:0]            off
);

    // Scanning downward leaves the lowest matching slot in place.
    always_comb begin
        any = 1'b0;
        idx = '0;
        off = 64'h0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (match[s]) begin
                any = 1'b1;
                idx = IDX_W'(s);
                off = offset[s];
            end
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bardec_pkg::*;
#(
    parameter logic [2*NSLOT-1:0] SLOT_KIND = 12'h336,
    parameter logic [NSLOT-1:0]   SLOT_PREF = 6'b000100,
    parameter logic [6*NSLOT-1:0] SLOT_LOG2 = {6'd0, 6'd33, 6'd0, 6'd20, 6'd5, 6'd12},
    parameter int                 DW_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic [DW_W-1:0]  cfg_dw,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             req_valid,
    input  logic             req_is_io,
    input  logic [63:0]      req_addr,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [63:0]      hit_off
);

    logic [NSLOT-1:0][31:0] slot_val;
    logic                   cmd_io;
    logic                   cmd_mem;
    logic [NSLOT-1:0]       match;
    logic [NSLOT-1:0][63:0] offset;
    logic                   pick_any;
    logic [IDX_W-1:0]       pick_idx;
    logic [63:0]            pick_off;
    logic                   take;

    bardec_regs #(
        .SLOT_KIND (SLOT_KIND),
        .SLOT_PREF (SLOT_PREF),
        .SLOT_LOG2 (SLOT_LOG2),
        .DW_W      (DW_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_we    (cfg_we),
        .cfg_dw    (cfg_dw),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .slot_val  (slot_val),
        .cmd_io    (cmd_io),
        .cmd_mem   (cmd_mem)
    );

    bardec_match #(
        .SLOT_KIND (SLOT_KIND),
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_match (
        .slot_val  (slot_val),
        .cmd_io    (cmd_io),
        .cmd_mem   (cmd_mem),
        .req_is_io (req_is_io),
        .req_addr  (req_addr),
        .match     (match),
        .offset    (offset)
    );

    bardec_pick u_pick (
        .match  (match),
        .offset (offset),
        .any    (pick_any),
        .idx    (pick_idx),
        .off    (pick_off)
    );

    assign take = req_valid && pick_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
            hit_off <= 64'h0;
        end else begin
            hit     <= take;
            hit_idx <= take ? pick_idx : '0;
            hit_off <= take ? pick_off : 64'h0;
        end
    end

endmodule

// File: rtl/bardec_chk.sv
module bardec_chk
    import bardec_pkg::*;
#(
    parameter logic [2*NSLOT-1:0] SLOT_KIND = 12'h336,
    parameter logic [6*NSLOT-1:0] SLOT_LOG2 = {6'd0, 6'd33, 6'd0, 6'd20, 6'd5, 6'd12},
    parameter int                 DW_W      = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_we,
    input logic [DW_W-1:0]  cfg_dw,
    input logic [31:0]      cfg_rdata,
    input logic             req_valid,
    input logic             req_is_io,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic [63:0]      hit_off,
    input logic             cmd_io,
    input logic             cmd_mem
);

    localparam int PAD = 1 << IDX_W;

    logic [PAD-1:0] base_pad;
    logic [PAD-1:0] io_pad;
    logic           unmapped_rd;

    assign base_pad    = PAD'(base_set(SLOT_KIND));
    assign io_pad      = PAD'(io_set(SLOT_KIND));
    assign unmapped_rd = cfg_en && !cfg_we && (cfg_dw != DW_W'(1)) &&
                         ((cfg_dw < DW_W'(4)) || (cfg_dw > DW_W'(3 + NSLOT)));

    AST_HIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(req_valid)); // R10

    AST_MISS_REPORTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0 && hit_off == 64'h0)); // R10

    AST_HIT_ON_WINDOW_START: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> base_pad[hit_idx]); // R5

    AST_OFFSET_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((hit_off >> log_at(SLOT_LOG2, int'(hit_idx))) == 64'h0)); // R6

    AST_SPACE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(req_is_io) == io_pad[hit_idx])); // R7

    AST_SPACE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(req_is_io) ? $past(cmd_io) : $past(cmd_mem))); // R8

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |=> (cfg_rdata == 32'h0)); // R5

endmodule

bind bar_window_decoder bardec_chk #(
    .SLOT_KIND (SLOT_KIND),
    .SLOT_LOG2 (SLOT_LOG2),
    .DW_W      (DW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_dw    (cfg_dw),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_is_io (req_is_io),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .hit_off   (hit_off),
    .cmd_io    (cmd_io),
    .cmd_mem   (cmd_mem)
);

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_dw = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic        hit;
    logic [2:0]  hit_idx;
    logic [63:0] hit_off;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    bar_window_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_we    (cfg_we),
        .cfg_dw    (cfg_dw),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_is_io (req_is_io),
        .req_addr  (req_addr),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_off   (hit_off)
    );

    // Window layout: slot0 mem32 4 KiB, slot1 I/O 32 B, slots2-3 mem64 prefetchable 1 MiB,
    // slots4-5 mem64 8 GiB.
    typedef struct packed {
        logic        io;
        logic [63:0] addr;
        logic        hit;
        logic [2:0]  idx;
        logic [63:0] off;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 64'h0000_0000_8000_0000, 1'b1, 3'd0, 64'h0},           // R6 first byte
        '{1'b0, 64'h0000_0000_8000_0FFF, 1'b1, 3'd0, 64'hFFF},         // R6 last byte
        '{1'b0, 64'h0000_0000_8000_1000, 1'b0, 3'd0, 64'h0},           // R6 one past
        '{1'b1, 64'h0000_0000_0000_1010, 1'b1, 3'd1, 64'h10},          // R7 io hit
        '{1'b1, 64'h0000_0000_0000_1020, 1'b0, 3'd0, 64'h0},           // R7 io one past
        '{1'b0, 64'h0000_0000_0000_1010, 1'b0, 3'd0, 64'h0},           // R7 mem at io base
        '{1'b1, 64'h0000_0000_8000_0004, 1'b0, 3'd0, 64'h0},           // R7 io at mem base
        '{1'b0, 64'h0000_0001_4001_2345, 1'b1, 3'd2, 64'h1_2345},      // R4 wide joined base
        '{1'b0, 64'h0000_0000_4000_0000, 1'b0, 3'd0, 64'h0},           // R4 upper dword differs
        '{1'b0, 64'h0000_0005_2345_6789, 1'b1, 3'd4, 64'h1_2345_6789}, // R4 above 4 GiB size
        '{1'b0, 64'h0000_0006_0000_0000, 1'b0, 3'd0, 64'h0},           // R4 one past
        '{1'b0, 64'h0000_0005_FFFF_FFFF, 1'b1, 3'd4, 64'h1_FFFF_FFFF}, // R4 last byte
        '{1'b0, 64'h0000_0001_8000_0000, 1'b0, 3'd0, 64'h0}            // R6 narrow window, upper set
    };

    localparam logic [31:0] RST_RD  [6] = '{32'h0, 32'h1, 32'hC, 32'h0, 32'h4, 32'h0};
    localparam logic [31:0] SIZE_RD [6] = '{32'hFFFF_F000, 32'hFFFF_FFE1, 32'hFFF0_000C,
                                            32'hFFFF_FFFF, 32'h0000_0004, 32'hFFFF_FFFE};

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int dw, input logic [31:0] d);
        cfg_en    = 1'b1;
        cfg_we    = 1'b1;
        cfg_dw    = 10'(dw);
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int dw, output logic [31:0] d);
        cfg_en = 1'b1;
        cfg_we = 1'b0;
        cfg_dw = 10'(dw);
        @(posedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic send(input logic io, input logic [63:0] a);
        req_valid = 1'b1;
        req_is_io = io;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_dec(input string tag, input logic h, input logic [2:0] i,
                              input logic [63:0] o);
        check(tag, "hit", 64'(hit), 64'(h));
        check(tag, "idx", 64'(hit_idx), 64'(i));
        check(tag, "off", hit_off, o);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R3 type bits
        for (int s = 0; s < 6; s++) begin
            cfg_read(4 + s, d);
            check("R1", $sformatf("reset read slot%0d", s), 64'(d), 64'(RST_RD[s]));
        end
        cfg_read(1, d);
        check("R1", "reset command", 64'(d), 64'h0);
        send(1'b0, 64'h0);
        expect_dec("R1", 1'b0, 3'd0, 64'h0);

        // R2 sizing readback, R4 upper-slot masks
        for (int s = 0; s < 6; s++) cfg_write(4 + s, 32'hFFFF_FFFF);
        for (int s = 0; s < 6; s++) begin
            cfg_read(4 + s, d);
            check(s == 3 || s == 5 ? "R4" : "R2", $sformatf("sizing slot%0d", s),
                  64'(d), 64'(SIZE_RD[s]));
        end

        // R5 unmapped indices ignore writes and read zero
        cfg_write(2, 32'hFFFF_FFFF);
        cfg_write(10, 32'hFFFF_FFFF);
        cfg_read(2, d);
        check("R5", "dword 2", 64'(d), 64'h0);
        cfg_read(10, d);
        check("R5", "dword 10", 64'(d), 64'h0);

        // Program windows and enables (command bit0 I/O, bit1 memory)
        cfg_write(4, 32'h8000_0000);
        cfg_write(5, 32'h0000_1000);
        cfg_write(6, 32'h4000_0000);
        cfg_write(7, 32'h0000_0001);
        cfg_write(8, 32'h0000_0000);
        cfg_write(9, 32'h0000_0004);
        cfg_write(1, 32'h3);
        cfg_read(1, d);
        check("R11", "command readback", 64'(d), 64'h3);
        cfg_read(6, d);
        check("R3", "prefetchable wide type", 64'(d), 64'h4000_000C);

        // Table walk: R4 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v].io, VEC[v].addr);
            expect_dec($sformatf("R6/R7 vec%0d", v), VEC[v].hit, VEC[v].idx, VEC[v].off);
        end

        // R10 no strobe gives no hit
        send(1'b0, 64'h8000_0010);
        expect_dec("R10", 1'b1, 3'd0, 64'h10);
        @(posedge clk);
        @(negedge clk);
        expect_dec("R10", 1'b0, 3'd0, 64'h0);

        // R9 overlap: slot0 and wide slot2 both at 0x4000_0000
        cfg_write(7, 32'h0);
        cfg_write(4, 32'h4000_0000);
        send(1'b0, 64'h4000_0010);
        expect_dec("R9", 1'b1, 3'd0, 64'h10);
        send(1'b0, 64'h4000_2000);
        expect_dec("R9", 1'b1, 3'd2, 64'h2000);

        // R8 gating applies on the very next request
        cfg_write(1, 32'h1);
        send(1'b0, 64'h4000_2000);
        expect_dec("R8", 1'b0, 3'd0, 64'h0);
        send(1'b1, 64'h1010);
        expect_dec("R8", 1'b1, 3'd1, 64'h10);
        cfg_write(1, 32'h2);
        send(1'b1, 64'h1010);
        expect_dec("R8", 1'b0, 3'd0, 64'h0);
        send(1'b0, 64'h4000_2000);
        expect_dec("R8", 1'b1, 3'd2, 64'h2000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule